// File: doc/BRIEF.md
# Dispatch Group Slot Tracker

This block tracks how many slots of the current instruction dispatch group are in use. For each candidate instruction it decides whether that instruction may join the group. A candidate is described by a unit class and a few flags:

- first-only
- single
- cracked (the decoder splits it into two operations)
- writes the count register
- branches indirectly through the count register
- flagged by a separate comparator as a load that overlaps an earlier store in the group

The tracker answers with one of three verdicts. No hazard means the candidate may join. Stall means it must wait for a later group. Pad means a no-op must be inserted before it.

A scheduler presents a candidate and reads the verdict in the same cycle. It then either pulses `commit` to place that instruction in the group, or pulses `advance` to let one empty cycle pass. Both update the slot count on the next rising clock edge. A group ends, and every piece of tracked state clears, when the count reaches the group size.

Top module: `dgroup_tracker`

## Requirements
- R1: With four slots used (count 4), any candidate other than a branch (class 7) or a pseudo (class 0) gets verdict stall (1).
- R2: A candidate flagged first-only or single gets stall (1) whenever the count is not zero. At count zero it may join.
- R3: A cracked candidate gets stall (1) when the count is above two. At count two it may join.
- R4: A condition-register-unit candidate (class 6) gets stall (1) at count two or more. At counts zero and one it may join.
- R5: Committing a branch (class 7), or any instruction flagged single, ends the group: the count reads zero after the edge.
- R6: A commit adds one to the count, or two if the instruction is cracked. When the result reaches five, the count returns to zero and all tracked state clears.
- R7: An advance without a commit adds one to the count. On reaching five the group ends and the count returns to zero.
- R8: Committing an instruction flagged as writing the count register arms a flag. While the flag is armed, a candidate that branches through the count register gets pad (2). The flag clears when the group ends, after which the same candidate gets no hazard (0).
- R9: A pseudo candidate (class 0) always gets no hazard (0), whatever its flags. Committing it leaves the count unchanged.
- R10: A candidate flagged as an overlapping load gets pad (2), except that any slot rule that refuses it (verdict stall) takes precedence.
- R11: Synchronous active-high reset gives count zero. The verdict depends only on the present inputs and state, within the same cycle.

Unit class encoding:

| Code | Class |
|---|---|
| 0 | pseudo |
| 1 | fixed-point |
| 2 | load/store |
| 3 | floating-point |
| 4 | vector ALU |
| 5 | vector permute |
| 6 | condition register |
| 7 | branch |

Verdict encoding: 0 = no hazard, 1 = stall, 2 = pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_unit | input | 3 | Unit class of the candidate |
| cand_first | input | 1 | Candidate must lead the group |
| cand_single | input | 1 | Candidate occupies a group alone |
| cand_cracked | input | 1 | Candidate takes two slots |
| cand_sets_cnt | input | 1 | Candidate writes the count register |
| cand_br_cnt | input | 1 | Candidate branches through the count register |
| cand_ld_overlap | input | 1 | Candidate is a load overlapping an earlier store in the group |
| commit | input | 1 | Place the candidate in the group at the next edge |
| advance | input | 1 | Let one empty cycle pass at the next edge |
| verdict | output | 2 | 0 no hazard, 1 stall, 2 pad |
| slots_used | output | 3 | Slots used in the current group |

## Verification
The verdict is combinational, so it is due in the same cycle as the candidate. The bench drives each candidate at a falling edge and compares the verdict a quarter period later, before the next rising edge. The slot count is due one rising edge after a commit or advance. The monitor therefore compares it just after that edge, against the value predicted from the requirements. Each queued item carries both expectations, so every stimulus is judged at exactly those two points.

// File: rtl/dg_pkg.sv
package dg_pkg;
  typedef enum logic [2:0] {
    UC_PSEUDO = 3'd0,
    UC_FIX    = 3'd1,
    UC_LDST   = 3'd2,
    UC_FLT    = 3'd3,
    UC_VALU   = 3'd4,
    UC_VPERM  = 3'd5,
    UC_CREG   = 3'd6,
    UC_BRANCH = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    VD_CLEAR = 2'd0,
    VD_STALL = 2'd1,
    VD_PAD   = 2'd2
  } verdict_e;
endpackage

// File: rtl/dg_rules.sv
module dg_rules
  import dg_pkg::*;
#(
  parameter int SLOTS     = 5,
  parameter int CR_SLOTS  = 2,
  parameter int CRACK_MAX = 2,
  parameter int CW        = 3
) (
  input  unit_e          unit,
  input  logic           first_only,
  input  logic           single,
  input  logic           cracked,
  input  logic           br_cnt,
  input  logic           ld_overlap,
  input  logic [CW-1:0]  used,
  input  logic           cnt_armed,
  output verdict_e       verdict
);
  localparam logic [CW-1:0] LAST_OPEN = CW'(SLOTS - 1);
  localparam logic [CW-1:0] CR_LIM    = CW'(CR_SLOTS);
  localparam logic [CW-1:0] CRK_LIM   = CW'(CRACK_MAX);

  logic slot_block;

  always_comb begin
    slot_block = 1'b0;
    if ((first_only || single) && used != '0) slot_block = 1'b1;
    if (cracked && used > CRK_LIM) slot_block = 1'b1;
    if (unit == UC_CREG) begin
      if (used >= CR_LIM) slot_block = 1'b1;
    end else if (unit != UC_BRANCH) begin
      if (used == LAST_OPEN) slot_block = 1'b1;
    end
  end

  always_comb begin
    if (unit == UC_PSEUDO)            verdict = VD_CLEAR;
    else if (slot_block)              verdict = VD_STALL;
    else if (cnt_armed && br_cnt)     verdict = VD_PAD;
    else if (ld_overlap)              verdict = VD_PAD;
    else                              verdict = VD_CLEAR;
  end
endmodule

// File: rtl/dg_state.sv
module dg_state
  import dg_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          advance,
  input  unit_e         unit,
  input  logic          single,
  input  logic          cracked,
  input  logic          sets_cnt,
  output logic [CW-1:0] used,
  output logic          cnt_armed
);
  localparam logic [CW:0] FULL  = (CW+1)'(SLOTS);
  localparam logic [CW:0] CLOSE = (CW+1)'(SLOTS - 1);

  logic        real_commit;
  logic [CW:0] base;
  logic [CW:0] nxt;

  assign real_commit = commit && (unit != UC_PSEUDO);

  always_comb begin
    base = {1'b0, used};
    nxt  = base;
    if (real_commit) begin
      if (unit == UC_BRANCH || single) base = CLOSE;
      nxt = base + (CW+1)'(1) + {{CW{1'b0}}, cracked};
    end else if (advance) begin
      nxt = base + (CW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used      <= '0;
      cnt_armed <= 1'b0;
    end else if (nxt >= FULL) begin
      used      <= '0;
      cnt_armed <= 1'b0;
    end else begin
      used <= nxt[CW-1:0];
      if (real_commit && sets_cnt) cnt_armed <= 1'b1;
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    used < CW'(SLOTS));

  // R7
  adv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !commit && used < CW'(SLOTS - 1)) |=> used == $past(used) + CW'(1));

  // R8
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (used == '0) |-> !cnt_armed);
endmodule

// File: rtl/dgroup_tracker.sv
module dgroup_tracker
  import dg_pkg::*;
#(
  parameter int  GROUP_SLOTS = 5,
  parameter int  CR_SLOTS    = 2,
  parameter int  CRACK_MAX   = 2,
  localparam int CW          = $clog2(GROUP_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cand_unit,
  input  logic          cand_first,
  input  logic          cand_single,
  input  logic          cand_cracked,
  input  logic          cand_sets_cnt,
  input  logic          cand_br_cnt,
  input  logic          cand_ld_overlap,
  input  logic          commit,
  input  logic          advance,
  output logic [1:0]    verdict,
  output logic [CW-1:0] slots_used
);
  unit_e         unit;
  verdict_e      vd;
  logic [CW-1:0] used;
  logic          armed;

  assign unit = unit_e'(cand_unit);

  dg_rules #(
    .SLOTS(GROUP_SLOTS), .CR_SLOTS(CR_SLOTS), .CRACK_MAX(CRACK_MAX), .CW(CW)
  ) u_rules (
    .unit(unit), .first_only(cand_first), .single(cand_single),
    .cracked(cand_cracked), .br_cnt(cand_br_cnt), .ld_overlap(cand_ld_overlap),
    .used(used), .cnt_armed(armed), .verdict(vd)
  );

  dg_state #(.SLOTS(GROUP_SLOTS), .CW(CW)) u_state (
    .clk(clk), .rst(rst), .commit(commit), .advance(advance),
    .unit(unit), .single(cand_single), .cracked(cand_cracked),
    .sets_cnt(cand_sets_cnt), .used(used), .cnt_armed(armed)
  );

  assign verdict    = vd;
  assign slots_used = used;

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit && advance));

  // R1
  fifth_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (slots_used == CW'(GROUP_SLOTS - 1) && unit != UC_BRANCH && unit != UC_PSEUDO)
      |-> verdict == 2'd1);

  // R9
  pseudo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && unit == UC_PSEUDO) |=> $stable(slots_used));

  // R5
  group_close_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && (unit == UC_BRANCH || (cand_single && unit != UC_PSEUDO)))
      |=> slots_used == '0);
endmodule

// File: tb/dgroup_tracker_test.sv
module dgroup_tracker_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cand_unit = 3'd0;
  logic cand_first = 0, cand_single = 0, cand_cracked = 0;
  logic cand_sets_cnt = 0, cand_br_cnt = 0, cand_ld_overlap = 0;
  logic commit = 0, advance = 0;
  logic [1:0] verdict;
  logic [2:0] slots_used;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0] q_v[$];
  logic [2:0] q_c[$];
  string      q_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dgroup_tracker uut (
    .clk(clk), .rst(rst), .cand_unit(cand_unit), .cand_first(cand_first),
    .cand_single(cand_single), .cand_cracked(cand_cracked),
    .cand_sets_cnt(cand_sets_cnt), .cand_br_cnt(cand_br_cnt),
    .cand_ld_overlap(cand_ld_overlap), .commit(commit), .advance(advance),
    .verdict(verdict), .slots_used(slots_used)
  );

  // flags: {first, single, cracked, sets_cnt, br_cnt, ld_overlap}
  task automatic step(input logic [2:0] u, input logic [5:0] fl,
                      input logic cm, input logic ad,
                      input logic [1:0] ev, input logic [2:0] ec, input string tag);
    @(negedge clk);
    cand_unit = u;
    {cand_first, cand_single, cand_cracked, cand_sets_cnt, cand_br_cnt, cand_ld_overlap} = fl;
    commit = cm;
    advance = ad;
    q_v.push_back(ev);
    q_c.push_back(ec);
    q_t.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q_v.size() > 0) begin
        checks++;
        if (verdict !== q_v[0]) begin
          fails++;
          $display("FAIL %s verdict: actual %0d expected %0d", q_t[0], verdict, q_v[0]);
        end
        @(posedge clk);
        #1;
        checks++;
        if (slots_used !== q_c[0]) begin
          fails++;
          $display("FAIL %s count: actual %0d expected %0d", q_t[0], slots_used, q_c[0]);
        end
        void'(q_v.pop_front());
        void'(q_c.pop_front());
        void'(q_t.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (slots_used !== 3'd0) begin
      fails++;
      $display("FAIL R11 reset count: actual %0d expected 0", slots_used);
    end
    step(3'd1, 6'b000000, 1, 0, 2'd0, 3'd1, "R6 R11 fix commit");
    step(3'd6, 6'b000000, 0, 0, 2'd0, 3'd1, "R4 creg at 1");
    step(3'd1, 6'b000000, 1, 0, 2'd0, 3'd2, "R6 fix commit");
    step(3'd6, 6'b000000, 0, 0, 2'd1, 3'd2, "R4 creg at 2");
    step(3'd1, 6'b001000, 1, 0, 2'd0, 3'd4, "R3 R6 cracked at 2");
    step(3'd3, 6'b000000, 0, 0, 2'd1, 3'd4, "R1 flt at 4");
    step(3'd5, 6'b000000, 0, 0, 2'd1, 3'd4, "R1 vperm at 4");
    step(3'd7, 6'b000000, 1, 0, 2'd0, 3'd0, "R5 R6 branch at 4");
    step(3'd1, 6'b100000, 0, 1, 2'd0, 3'd1, "R2 R7 first at 0");
    step(3'd1, 6'b100000, 0, 0, 2'd1, 3'd1, "R2 first at 1");
    step(3'd2, 6'b010000, 0, 0, 2'd1, 3'd1, "R2 single at 1");
    step(3'd0, 6'b111111, 1, 0, 2'd0, 3'd1, "R9 pseudo commit");
    step(3'd1, 6'b001000, 0, 1, 2'd0, 3'd2, "R3 cracked at 1");
    step(3'd1, 6'b001000, 0, 1, 2'd0, 3'd3, "R3 cracked at 2");
    step(3'd1, 6'b001000, 0, 0, 2'd1, 3'd3, "R3 cracked at 3");
    step(3'd0, 6'b000000, 0, 1, 2'd0, 3'd4, "R7 advance to 4");
    step(3'd0, 6'b000000, 0, 1, 2'd0, 3'd0, "R7 advance ends group");
    step(3'd1, 6'b000100, 1, 0, 2'd0, 3'd1, "R8 set count reg");
    step(3'd0, 6'b000000, 0, 1, 2'd0, 3'd2, "R8 advance");
    step(3'd7, 6'b000010, 0, 0, 2'd2, 3'd2, "R8 branch via count");
    step(3'd0, 6'b000011, 0, 0, 2'd0, 3'd2, "R9 pseudo armed");
    step(3'd0, 6'b000000, 0, 1, 2'd0, 3'd3, "R7 advance");
    step(3'd0, 6'b000000, 0, 1, 2'd0, 3'd4, "R7 advance");
    step(3'd0, 6'b000000, 0, 1, 2'd0, 3'd0, "R7 R6 group end");
    step(3'd7, 6'b000010, 0, 0, 2'd0, 3'd0, "R8 flag cleared");
    step(3'd2, 6'b010000, 1, 0, 2'd0, 3'd0, "R5 single commit");
    step(3'd2, 6'b000001, 0, 0, 2'd2, 3'd0, "R10 overlap at 0");
    step(3'd1, 6'b001000, 1, 0, 2'd0, 3'd2, "R6 cracked commit");
    step(3'd4, 6'b001000, 1, 0, 2'd0, 3'd4, "R6 cracked to 4");
    step(3'd2, 6'b000001, 0, 0, 2'd1, 3'd4, "R10 overlap at 4");
    step(3'd7, 6'b000000, 0, 0, 2'd0, 3'd4, "R1 branch at 4");
    step(3'd7, 6'b000000, 1, 0, 2'd0, 3'd0, "R5 branch closes");
    @(negedge clk);
    cand_unit = 3'd0;
    {cand_first, cand_single, cand_cracked, cand_sets_cnt, cand_br_cnt, cand_ld_overlap} = 6'b0;
    commit = 0;
    advance = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule